// File: doc/BRIEF.md
# CAN Transmit Mailbox Status Unit

This block holds the 32-bit transmit status word for a CAN controller with three transmit mailboxes. The transmit engine reports per-mailbox outcomes as one-cycle pulses: request complete, transmit success, arbitration lost and transmit error. The unit latches each outcome as a sticky flag. Software clears a flag by writing a one to its bit.

Software can also raise an abort request per mailbox through the same write port. The request stays raised until that mailbox becomes empty. The abort requests leave the block as a separate output vector that the engine acts on.

Each cycle the unit samples every mailbox's pending state and priority key. From these it registers three things:

- the empty indicators;
- a one-hot marker on the pending mailbox with the lowest priority, shown only when at least two mailboxes are pending;
- a 2-bit code that names either the first free mailbox or, when none is free, the lowest-priority pending one.

Top module: `can_txmb_status`

## Requirements
- R1: After reset `status_word` is 0x1C00_0000 and `abort_req` is 0.
- R2: Mailbox m owns byte m of the word (bits 8m+7..8m). A one-cycle pulse on `evt_done[m]`, `evt_ok[m]`, `evt_alst[m]` or `evt_terr[m]` sets bit 0, 1, 2 or 3 of that byte respectively, visible from the cycle after the pulse. Bits 6..4 of each byte read 0.
- R3: A write (`wr_en`=1) with a 1 in an event flag's bit position clears that flag. A 0 in that position leaves the flag unchanged.
- R4: Bit 26+m reads 1 exactly when `mb_pending[m]` was 0 in the previous cycle.
- R5: When two or more mailboxes were pending, bit 29+m is set only for the pending mailbox with the numerically largest key in `mb_key[KEY_W*m +: KEY_W]`. On equal keys the higher mailbox number wins.
- R6: When fewer than two mailboxes were pending, bits 31..29 read 0.
- R7: Writing a 1 to bit 7 of byte m sets abort request m while mailbox m is pending. `abort_req[m]` mirrors that bit. Writing 0 there never clears it.
- R8: An abort request clears when its mailbox is not pending. A write to the abort bit of a non-pending mailbox has no effect.
- R9: Bits 25..24 give the lowest-numbered empty mailbox if any mailbox is empty, otherwise the lowest-priority mailbox.
- R10: When an event pulse and a write-1 clear hit the same flag in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_done | input | 3 | Per-mailbox request-complete pulse |
| evt_ok | input | 3 | Per-mailbox transmit-success pulse |
| evt_alst | input | 3 | Per-mailbox arbitration-lost pulse |
| evt_terr | input | 3 | Per-mailbox transmit-error pulse |
| mb_pending | input | 3 | Mailbox holds a frame awaiting transmission |
| mb_key | input | 3*KEY_W | Priority keys, mailbox m in slice m |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 32 | Write data (1 clears event flags, 1 sets aborts) |
| status_word | output | 32 | Transmit status word |
| abort_req | output | 3 | Per-mailbox abort request |

## Verification
Several properties are checked on every cycle:

- the lowest-priority marker is one-hot or zero;
- the marker never points at an empty mailbox;
- the marker stays zero unless at least two mailboxes are pending;
- the code names an empty mailbox whenever one exists;
- an event pulse always leaves its flag set;
- an abort holds while its mailbox stays pending and drops once the mailbox empties.

Only the directed scenarios can show the rest. These cover the exact byte placement of each flag, which key actually wins, and tie breaking toward the higher mailbox. They also cover the reset value and the fact that writing zeros or writing to an empty mailbox changes nothing.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

    localparam int NUM_MB = 3;
    localparam int IDX_W  = $clog2(NUM_MB);

    // positions inside one mailbox byte
    localparam int B_DONE  = 0;
    localparam int B_OK    = 1;
    localparam int B_ALST  = 2;
    localparam int B_TERR  = 3;
    localparam int B_ABORT = 7;

    // positions in the upper byte of the status word
    localparam int W_CODE_LO  = 24;
    localparam int W_EMPTY_LO = 26;
    localparam int W_LOW_LO   = 29;

    typedef struct packed {
        logic abort;
        logic terr;
        logic alst;
        logic ok;
        logic done;
    } mb_flags_t;

endpackage

// File: rtl/can_txmb_flags.sv
module can_txmb_flags
    import can_txmb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_done,
    input  logic       set_ok,
    input  logic       set_alst,
    input  logic       set_terr,
    input  logic       pending,
    input  logic       wr_en,
    input  logic [3:0] wr_clr,
    input  logic       wr_abort,
    output logic [7:0] stat_byte,
    output logic       abort_out
);

    mb_flags_t fl_d, fl_q;
    logic [3:0] clr;

    always_comb begin
        clr        = wr_en ? wr_clr : 4'b0000;
        fl_d       = fl_q;
        // hardware set has priority over software clear
        fl_d.done  = (fl_q.done & ~clr[B_DONE]) | set_done;
        fl_d.ok    = (fl_q.ok   & ~clr[B_OK])   | set_ok;
        fl_d.alst  = (fl_q.alst & ~clr[B_ALST]) | set_alst;
        fl_d.terr  = (fl_q.terr & ~clr[B_TERR]) | set_terr;
        // abort is software set-only and exists only while the mailbox is pending
        fl_d.abort = (fl_q.abort | (wr_en & wr_abort)) & pending;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign stat_byte = {fl_q.abort, 3'b000, fl_q.terr, fl_q.alst, fl_q.ok, fl_q.done};
    assign abort_out = fl_q.abort;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> fl_q.done);  // R10
    AST_CLEAR_NEEDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.ok && !(wr_en && wr_clr[B_OK])) |=> fl_q.ok);  // R3
    AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.abort && pending) |=> fl_q.abort);  // R7
    AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !fl_q.abort);  // R8

endmodule

// File: rtl/can_txmb_rank.sv
module can_txmb_rank
    import can_txmb_pkg::*;
#(
    parameter int KEY_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_MB-1:0]       pending,
    input  logic [NUM_MB*KEY_W-1:0] keys,
    output logic [NUM_MB-1:0]       empty_o,
    output logic [NUM_MB-1:0]       low_o,
    output logic [IDX_W-1:0]        code_o
);

    typedef struct packed {
        logic [NUM_MB-1:0] empty;
        logic [NUM_MB-1:0] low;
        logic [IDX_W-1:0]  code;
    } rank_t;

    rank_t r_d, r_q;

    logic [KEY_W-1:0] best_key;
    logic [IDX_W-1:0] best_idx;
    logic             found;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;
    int unsigned      n_pend;

    always_comb begin
        best_key = '0;
        best_idx = '0;
        found    = 1'b0;
        n_pend   = 0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (pending[i]) begin
                n_pend = n_pend + 1;
                // >= hands ties to the higher index
                if (!found || keys[i*KEY_W +: KEY_W] >= best_key) begin
                    best_key = keys[i*KEY_W +: KEY_W];
                    best_idx = IDX_W'(i);
                end
                found = 1'b1;
            end
        end

        free_idx = '0;
        any_free = 1'b0;
        for (int i = NUM_MB-1; i >= 0; i--) begin
            if (!pending[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end

        r_d       = r_q;
        r_d.empty = ~pending;
        r_d.low   = '0;
        if (n_pend >= 2) r_d.low[best_idx] = 1'b1;
        r_d.code  = any_free ? free_idx : best_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.empty <= '1;
            r_q.low   <= '0;
            r_q.code  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign empty_o = r_q.empty;
    assign low_o   = r_q.low;
    assign code_o  = r_q.code;

    AST_LOW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(r_q.low));  // R5
    AST_LOW_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.low & r_q.empty) == '0);  // R5
    AST_LOW_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~r_q.empty) < 2) |-> (r_q.low == '0));  // R6
    AST_CODE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.empty != '0) |-> (((r_q.empty >> r_q.code) & 1) != '0));  // R9

endmodule

// File: rtl/can_txmb_status.sv
module can_txmb_status
    import can_txmb_pkg::*;
#(
    parameter int KEY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         evt_done,
    input  logic [2:0]         evt_ok,
    input  logic [2:0]         evt_alst,
    input  logic [2:0]         evt_terr,
    input  logic [2:0]         mb_pending,
    input  logic [3*KEY_W-1:0] mb_key,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    output logic [31:0]        status_word,
    output logic [2:0]         abort_req
);

    logic [NUM_MB-1:0] empty_q, low_q;
    logic [IDX_W-1:0]  code_q;
    logic [7:0]        mb_byte [NUM_MB];
    logic              unused_wr;

    assign unused_wr = ^{wr_data[31:24], wr_data[22:20], wr_data[14:12], wr_data[6:4]};

    for (genvar m = 0; m < NUM_MB; m++) begin : g_mb
        can_txmb_flags u_flags (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_done  (evt_done[m]),
            .set_ok    (evt_ok[m]),
            .set_alst  (evt_alst[m]),
            .set_terr  (evt_terr[m]),
            .pending   (mb_pending[m]),
            .wr_en     (wr_en),
            .wr_clr    (wr_data[8*m +: 4]),
            .wr_abort  (wr_data[8*m + B_ABORT]),
            .stat_byte (mb_byte[m]),
            .abort_out (abort_req[m])
        );
    end

    can_txmb_rank #(.KEY_W(KEY_W)) u_rank (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (mb_pending),
        .keys    (mb_key),
        .empty_o (empty_q),
        .low_o   (low_q),
        .code_o  (code_q)
    );

    always_comb begin
        status_word = '0;
        for (int m = 0; m < NUM_MB; m++) begin
            status_word[8*m +: 8]       = mb_byte[m];
            status_word[W_EMPTY_LO + m] = empty_q[m];
            status_word[W_LOW_LO + m]   = low_q[m];
        end
        status_word[W_CODE_LO +: IDX_W] = code_q;
    end

endmodule

// File: tb/tb_can_txmb_status.sv
module tb_can_txmb_status;

    localparam int CLK_PERIOD = 10;
    localparam int KEY_W      = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [2:0]         evt_done = '0, evt_ok = '0, evt_alst = '0, evt_terr = '0;
    logic [2:0]         mb_pending = '0;
    logic [3*KEY_W-1:0] mb_key = '0;
    logic               wr_en = 1'b0;
    logic [31:0]        wr_data = '0;
    logic [31:0]        status_word;
    logic [2:0]         abort_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_txmb_status #(.KEY_W(KEY_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .evt_done(evt_done), .evt_ok(evt_ok), .evt_alst(evt_alst), .evt_terr(evt_terr),
        .mb_pending(mb_pending), .mb_key(mb_key),
        .wr_en(wr_en), .wr_data(wr_data),
        .status_word(status_word), .abort_req(abort_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // one clock edge, then sample at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic set_mb(input logic [2:0] p, input logic [7:0] k2, input logic [7:0] k1, input logic [7:0] k0);
        mb_pending = p; mb_key = {k2, k1, k0};
        step();
    endtask

    task automatic t_reset();
        check("R1 reset word", status_word, 32'h1C00_0000);
        check("R1 reset abort", {29'd0, abort_req}, 32'd0);
    endtask

    task automatic t_events();
        evt_done = 3'b001; evt_ok = 3'b001;
        step();
        evt_done = '0; evt_ok = '0;
        check("R2 mb0 done+ok", status_word, 32'h1C00_0003);
        evt_alst = 3'b010; evt_terr = 3'b100;
        step();
        evt_alst = '0; evt_terr = '0;
        check("R2 mb1 alst mb2 terr", status_word, 32'h1C08_0403);
        step();
        check("R2 flags sticky", status_word, 32'h1C08_0403);
    endtask

    task automatic t_w1c();
        do_write(32'h0000_0000);
        check("R3 write zero keeps", status_word, 32'h1C08_0403);
        do_write(32'h0000_0001);
        check("R3 clear mb0 done only", status_word, 32'h1C08_0402);
        do_write(32'h000F_0F0F);
        check("R3 clear all", status_word, 32'h1C00_0000);
    endtask

    task automatic t_set_wins();
        evt_done = 3'b010; wr_en = 1'b1; wr_data = 32'h0000_0100;
        step();
        evt_done = '0; wr_en = 1'b0; wr_data = '0;
        check("R10 set beats clear", status_word, 32'h1C00_0100);
        do_write(32'h0000_0100);
        check("R3 clear after conflict", status_word, 32'h1C00_0000);
    endtask

    task automatic t_rank();
        set_mb(3'b001, 8'd50, 8'd60, 8'd70);
        check("R4 R6 R9 single pending", status_word, 32'h1900_0000);
        set_mb(3'b011, 8'd0, 8'd9, 8'd5);
        check("R5 R9 two pending mb1 low", status_word, 32'h5200_0000);
        set_mb(3'b111, 8'd3, 8'd7, 8'd7);
        check("R5 tie to higher index", status_word, 32'h4100_0000);
        set_mb(3'b111, 8'd1, 8'd2, 8'd3);
        check("R5 R9 mb0 low", status_word, 32'h2000_0000);
        set_mb(3'b101, 8'd200, 8'd255, 8'd10);
        check("R5 R4 mb2 low mb1 empty", status_word, 32'h8900_0000);
        set_mb(3'b000, 8'd0, 8'd0, 8'd0);
        check("R4 R6 all empty", status_word, 32'h1C00_0000);
    endtask

    task automatic t_abort();
        set_mb(3'b111, 8'd0, 8'd0, 8'd0);
        check("R5 equal keys mb2 low", status_word, 32'h8200_0000);
        do_write(32'h0000_0080);
        check("R7 abort mb0 word", status_word, 32'h8200_0080);
        check("R7 abort mb0 port", {29'd0, abort_req}, 32'd1);
        do_write(32'h0000_0000);
        check("R7 write zero keeps abort", {29'd0, abort_req}, 32'd1);
        do_write(32'h0080_8000);
        check("R7 abort all", status_word, 32'h8280_8080);
        set_mb(3'b110, 8'd0, 8'd0, 8'd0);
        check("R8 mb0 empties", status_word, 32'h8480_8000);
        check("R8 abort port after empty", {29'd0, abort_req}, 32'd6);
        do_write(32'h0000_0080);
        check("R8 write to empty ignored", {29'd0, abort_req}, 32'd6);
        set_mb(3'b000, 8'd0, 8'd0, 8'd0);
        check("R8 all cleared", status_word, 32'h1C00_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_w1c();
        t_set_wins();
        t_rank();
        t_abort();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule